// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block merges event flags from a network datapath and a management (PHY access) interface into one active-high, level-sensitive interrupt line. A 32-bit main status register collects the datapath events. A 16-bit management status register collects link events. Each has its own mask register, where a 1 disables a source. The management register is not OR-ed into the line directly. Its qualified bits are folded into a single summary position (bit 23) of the main status, and only that position feeds the line.

Software reaches the four registers through a plain word-wide register port. Reading a status register clears it as a side effect. For the main status, every bit is cleared except the summary position. Two legacy offsets are also decoded as aliases of the main status and main mask registers. Event pulses arrive from the datapath on dedicated pins. All register port signals and event pins are single-cycle control strobes with no back-pressure, so no valid/ready handshake is used. A read is always accepted in the cycle it is presented.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the main mask reads 0xff7fffff, the management mask reads 0x0000ffff, both status registers read 0 and `irq` is 0.
- R2: `irq` is a register: it is 1 exactly when, one cycle earlier, some main status bit other than bit 23 was set with its main mask bit 0, or R3's summary condition held. A mask bit of 1 disables its source.
- R3: The summary condition is that some bit of the 16-bit management status is set while the same bit of the management mask is 0. When it holds, `irq` rises even if every other main bit is masked.
- R4: Bit 23 of the main mask is ignored. A stored 1 in bit 23 of the main status never raises `irq` by itself.
- R5: Each event pin sets one main status bit at the next clock edge: `ev_rx_done` sets bit 16, `ev_no_rx_desc` sets bit 17, `ev_tx_done` sets bit 24 and `ev_tx_all` sets bit 25.
- R6: A read of main status returns the stored value, then clears every bit except bit 23.
- R7: A read of management status returns the stored value, then clears it to zero.
- R8: Byte offset 0x108 is treated as 0x100 (main status, clear-on-read included), and 0x10c is treated as 0x104 (main mask).
- R9: An `ev_link_chg` pulse sets the management status to 0xffff.
- R10: An event that coincides with a clear-on-read or a write of the same register survives: set wins over clear and is OR-ed into written data.
- R11: Register map: 0x100 main status, 0x104 main mask, 0x120 management status, 0x124 management mask. Address bits [1:0] are ignored. A read presented in cycle N returns `rd_data` with `rd_valid` high in cycle N+1. Any other offset reads 0.
- R12: Writes store the written word. The management registers keep only bits [15:0], and their upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte offset |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the access |
| rd_valid | output | 1 | Read data valid |
| ev_rx_done | input | 1 | Receive frame delivered event |
| ev_no_rx_desc | input | 1 | No receive descriptor event |
| ev_tx_done | input | 1 | Transmit descriptor done event |
| ev_tx_all | input | 1 | Transmit all clear event |
| ev_link_chg | input | 1 | Link state change event |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions check the following properties on every cycle:
- the clear-on-read effect on both status registers, including retention of bit 23;
- the event-to-bit placement;
- the link-change fill value;
- the read-valid timing;
- the two interrupt implications: a masked-out main register stays quiet, and a qualified management bit raises the line.

Only the bench's scenarios can show other behaviour. This covers the alias decoding, the exact returned values, reset defaults, truncation of management writes, and collisions of events with reads. It also covers the fact that bit 23 written into the main status stays silent even when fully unmasked.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int DATA_W      = 32;
  parameter int MGMT_W      = 16;
  parameter int SUMMARY_BIT = 23;
  parameter int NUM_EV      = 4;

  localparam logic [31:0] MAIN_MASK_RST = 32'hff7f_ffff;
  localparam logic [31:0] MGMT_MASK_RST = 32'h0000_ffff;

  localparam int OFS_MAIN_STAT     = 'h100;
  localparam int OFS_MAIN_MASK     = 'h104;
  localparam int OFS_MAIN_STAT_ALT = 'h108;
  localparam int OFS_MAIN_MASK_ALT = 'h10c;
  localparam int OFS_MGMT_STAT     = 'h120;
  localparam int OFS_MGMT_MASK     = 'h124;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MAIN_STAT,
    SEL_MAIN_MASK,
    SEL_MGMT_STAT,
    SEL_MGMT_MASK
  } reg_sel_e;

  // main-status bit position of datapath event i
  function automatic int ev_bit(input int i);
    case (i)
      0:       ev_bit = 16;
      1:       ev_bit = 17;
      2:       ev_bit = 24;
      default: ev_bit = 25;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:0] word_addr;

  assign word_addr = {addr[ADDR_W-1:2], 2'b00};

  always_comb begin
    if (word_addr == ADDR_W'(OFS_MAIN_STAT) || word_addr == ADDR_W'(OFS_MAIN_STAT_ALT))
      sel = SEL_MAIN_STAT;
    else if (word_addr == ADDR_W'(OFS_MAIN_MASK) || word_addr == ADDR_W'(OFS_MAIN_MASK_ALT))
      sel = SEL_MAIN_MASK;
    else if (word_addr == ADDR_W'(OFS_MGMT_STAT))
      sel = SEL_MGMT_STAT;
    else if (word_addr == ADDR_W'(OFS_MGMT_MASK))
      sel = SEL_MGMT_MASK;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_agg_stat_reg.sv
module irq_agg_stat_reg #(
  parameter int          W    = 32,
  parameter logic [31:0] KEEP = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] stat_q
);
  localparam logic [W-1:0] KEEP_W = KEEP[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      stat_q <= '0;
    else if (wr_en)
      stat_q <= wdata | set_vec;
    else if (rd_clr)
      stat_q <= (stat_q & KEEP_W) | set_vec;
    else
      stat_q <= stat_q | set_vec;
  end
endmodule

// File: rtl/irq_agg_mask_reg.sv
module irq_agg_mask_reg #(
  parameter int          W   = 32,
  parameter logic [31:0] RST = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= RST[W-1:0];
    else if (wr_en) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine #(
  parameter int DATA_W      = 32,
  parameter int MGMT_W      = 16,
  parameter int SUMMARY_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] main_stat,
  input  logic [DATA_W-1:0] main_mask,
  input  logic [MGMT_W-1:0] mgmt_stat,
  input  logic [MGMT_W-1:0] mgmt_mask,
  output logic              irq_q
);
  localparam logic [DATA_W-1:0] SUM_ONE = DATA_W'(1) << SUMMARY_BIT;

  logic [DATA_W-1:0] main_en;
  logic              mgmt_hit;
  logic [DATA_W-1:0] eff;

  // summary position enabled only through the management path
  assign main_en  = ~main_mask & ~SUM_ONE;
  assign mgmt_hit = |(mgmt_stat & ~mgmt_mask);
  assign eff      = (main_stat & main_en) | (mgmt_hit ? SUM_ONE : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |eff;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              ev_rx_done,
  input  logic              ev_no_rx_desc,
  input  logic              ev_tx_done,
  input  logic              ev_tx_all,
  input  logic              ev_link_chg,
  output logic              irq
);
  localparam logic [31:0] MAIN_KEEP = 32'(1) << SUMMARY_BIT;

  reg_sel_e          acc_sel;
  logic [NUM_EV-1:0] ev_vec;
  logic [DATA_W-1:0] main_set;
  logic [MGMT_W-1:0] mgmt_set;
  logic [DATA_W-1:0] main_stat_q, main_mask_q;
  logic [MGMT_W-1:0] mgmt_stat_q, mgmt_mask_q;
  logic              rd_req, wr_req;
  logic [31:0]       rd_mux;

  assign rd_req = acc_en && !acc_wr;
  assign wr_req = acc_en && acc_wr;

  irq_agg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (acc_addr),
    .sel  (acc_sel)
  );

  assign ev_vec = {ev_tx_all, ev_tx_done, ev_no_rx_desc, ev_rx_done};

  always_comb begin
    main_set = '0;
    for (int i = 0; i < NUM_EV; i++)
      main_set[ev_bit(i)] = main_set[ev_bit(i)] | ev_vec[i];
  end

  assign mgmt_set = {MGMT_W{ev_link_chg}};

  irq_agg_stat_reg #(.W(DATA_W), .KEEP(MAIN_KEEP)) u_main_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req && acc_sel == SEL_MAIN_STAT),
    .rd_clr  (rd_req && acc_sel == SEL_MAIN_STAT),
    .wdata   (acc_wdata[DATA_W-1:0]),
    .set_vec (main_set),
    .stat_q  (main_stat_q)
  );

  irq_agg_stat_reg #(.W(MGMT_W), .KEEP(32'h0)) u_mgmt_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req && acc_sel == SEL_MGMT_STAT),
    .rd_clr  (rd_req && acc_sel == SEL_MGMT_STAT),
    .wdata   (acc_wdata[MGMT_W-1:0]),
    .set_vec (mgmt_set),
    .stat_q  (mgmt_stat_q)
  );

  irq_agg_mask_reg #(.W(DATA_W), .RST(MAIN_MASK_RST)) u_main_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_req && acc_sel == SEL_MAIN_MASK),
    .wdata  (acc_wdata[DATA_W-1:0]),
    .mask_q (main_mask_q)
  );

  irq_agg_mask_reg #(.W(MGMT_W), .RST(MGMT_MASK_RST)) u_mgmt_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_req && acc_sel == SEL_MGMT_MASK),
    .wdata  (acc_wdata[MGMT_W-1:0]),
    .mask_q (mgmt_mask_q)
  );

  irq_agg_combine #(
    .DATA_W      (DATA_W),
    .MGMT_W      (MGMT_W),
    .SUMMARY_BIT (SUMMARY_BIT)
  ) u_combine (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_stat (main_stat_q),
    .main_mask (main_mask_q),
    .mgmt_stat (mgmt_stat_q),
    .mgmt_mask (mgmt_mask_q),
    .irq_q     (irq)
  );

  always_comb begin
    case (acc_sel)
      SEL_MAIN_STAT: rd_mux = 32'(main_stat_q);
      SEL_MAIN_MASK: rd_mux = 32'(main_mask_q);
      SEL_MGMT_STAT: rd_mux = 32'(mgmt_stat_q);
      SEL_MGMT_MASK: rd_mux = 32'(mgmt_mask_q);
      default:       rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input reg_sel_e          acc_sel,
  input logic              ev_rx_done,
  input logic              ev_no_rx_desc,
  input logic              ev_tx_done,
  input logic              ev_tx_all,
  input logic              ev_link_chg,
  input logic [DATA_W-1:0] main_stat_q,
  input logic [DATA_W-1:0] main_mask_q,
  input logic [MGMT_W-1:0] mgmt_stat_q,
  input logic [MGMT_W-1:0] mgmt_mask_q,
  input logic              rd_valid,
  input logic              irq
);
  localparam logic [DATA_W-1:0] SUM_ONE = DATA_W'(1) << SUMMARY_BIT;

  logic ev_any, rd_main, rd_mgmt;
  assign ev_any  = ev_rx_done | ev_no_rx_desc | ev_tx_done | ev_tx_all;
  assign rd_main = acc_en && !acc_wr && acc_sel == SEL_MAIN_STAT;
  assign rd_mgmt = acc_en && !acc_wr && acc_sel == SEL_MGMT_STAT;

  // R6
  main_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main && !ev_any) |=> ((main_stat_q & ~SUM_ONE) == '0));

  // R6
  main_rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_main |=> (main_stat_q[SUMMARY_BIT] == $past(main_stat_q[SUMMARY_BIT])));

  // R7
  mgmt_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mgmt && !ev_link_chg) |=> (mgmt_stat_q == '0));

  // R9
  link_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_chg |=> (mgmt_stat_q == '1));

  // R5
  rx_done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> main_stat_q[16]);

  // R5
  tx_all_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_all |=> main_stat_q[25]);

  // R4
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((main_stat_q & ~main_mask_q & ~SUM_ONE) == '0) &&
     ((mgmt_stat_q & ~mgmt_mask_q) == '0)) |=> !irq);

  // R3
  mgmt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mgmt_stat_q & ~mgmt_mask_q) != '0) |=> irq);

  // R11
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rd_valid);

  // R11
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rd_valid);
endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        ev_rx_done = 0, ev_no_rx_desc = 0, ev_tx_done = 0, ev_tx_all = 0, ev_link_chg = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_aggregator u_dut (.*);

  // behavioural reference model
  logic [31:0] m_main, m_mmask, m_rd;
  logic [15:0] m_mgmt, m_gmask;
  logic        m_irq, m_rdv;

  function automatic int m_decode(input logic [11:0] a);
    case ({a[11:2], 2'b00})
      12'h100, 12'h108: return 1;
      12'h104, 12'h10c: return 2;
      12'h120:          return 3;
      12'h124:          return 4;
      default:          return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_main = 0; m_mmask = 32'hff7fffff; m_mgmt = 0; m_gmask = 16'hffff;
      m_irq = 0; m_rdv = 0; m_rd = 0;
    end else begin
      logic [31:0] mset, mval;
      int r;
      mval  = 0;
      m_irq = ((m_main & ~m_mmask & 32'hff7fffff) != 0) || ((m_mgmt & ~m_gmask) != 0);
      mset  = (ev_rx_done ? 32'h10000 : 0) | (ev_no_rx_desc ? 32'h20000 : 0) |
              (ev_tx_done ? 32'h1000000 : 0) | (ev_tx_all ? 32'h2000000 : 0);
      r = m_decode(acc_addr);
      m_rdv = acc_en && !acc_wr;
      if (r == 1) mval = m_main;
      else if (r == 2) mval = m_mmask;
      else if (r == 3) mval = {16'h0, m_mgmt};
      else if (r == 4) mval = {16'h0, m_gmask};
      if (m_rdv) m_rd = mval;
      if (acc_en && acc_wr) begin
        if (r == 1) m_main = acc_wdata;
        if (r == 2) m_mmask = acc_wdata;
        if (r == 3) m_mgmt = acc_wdata[15:0];
        if (r == 4) m_gmask = acc_wdata[15:0];
      end else if (m_rdv) begin
        if (r == 1) m_main = m_main & 32'h00800000;
        if (r == 3) m_mgmt = 0;
      end
      m_main = m_main | mset;
      if (ev_link_chg) m_mgmt = 16'hffff;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", {31'h0, irq}, {31'h0, m_irq});
      chk("R11", {31'h0, rd_valid}, {31'h0, m_rdv});
      if (m_rdv) chk("R11", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    acc_en = 1; acc_wr = 0; acc_addr = a;
    @(negedge clk);
    d = rd_data;
    acc_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset defaults
    rd(12'h104, v); chk("R1 main mask", v, 32'hff7fffff);
    rd(12'h124, v); chk("R1 mgmt mask", v, 32'h0000ffff);
    rd(12'h100, v); chk("R1 main stat", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R2 R5 R6: unmask bit 16, raise, read-clear
    wr(12'h104, 32'hfffeffff);
    ev_rx_done = 1; idle(1); ev_rx_done = 0;
    idle(1); chk("R2 irq up", {31'h0, irq}, 1);
    rd(12'h100, v); chk("R5 rx bit16", v, 32'h00010000);
    idle(1); chk("R6 irq cleared", {31'h0, irq}, 0);

    // R2 masked source stays quiet, R5 bit 17
    ev_no_rx_desc = 1; idle(1); ev_no_rx_desc = 0;
    idle(2); chk("R2 masked", {31'h0, irq}, 0);
    rd(12'h100, v); chk("R5 bit17", v, 32'h00020000);

    // R4 bit 23 of main mask ignored
    wr(12'h104, 32'h0);
    wr(12'h100, 32'h00800000);
    idle(2); chk("R4 irq quiet", {31'h0, irq}, 0);
    rd(12'h100, v); chk("R6 read", v, 32'h00800000);
    rd(12'h100, v); chk("R6 bit23 kept", v, 32'h00800000);
    wr(12'h100, 32'h0);
    wr(12'h104, 32'hffffffff);

    // R3 R7 R9 management path
    ev_link_chg = 1; idle(1); ev_link_chg = 0;
    idle(2); chk("R3 masked mgmt", {31'h0, irq}, 0);
    wr(12'h124, 32'h0000fffe);
    idle(2); chk("R3 summary irq", {31'h0, irq}, 1);
    rd(12'h120, v); chk("R9 link fill", v, 32'h0000ffff);
    idle(1); chk("R7 irq cleared", {31'h0, irq}, 0);
    rd(12'h120, v); chk("R7 cleared", v, 0);

    // R12 mgmt width
    wr(12'h124, 32'habcd1234);
    rd(12'h124, v); chk("R12 truncation", v, 32'h00001234);
    wr(12'h124, 32'h0000ffff);

    // R8 aliases
    wr(12'h10c, 32'h12345678);
    rd(12'h104, v); chk("R8 mask alias", v, 32'h12345678);
    rd(12'h10c, v); chk("R8 mask alias rd", v, 32'h12345678);
    wr(12'h100, 32'h03000000);
    rd(12'h108, v); chk("R8 stat alias", v, 32'h03000000);
    rd(12'h100, v); chk("R8 alias cleared", v, 0);
    wr(12'h104, 32'hffffffff);

    // R10 set beats clear
    ev_tx_done = 1; rd(12'h100, v); ev_tx_done = 0;
    chk("R10 pre value", v, 0);
    rd(12'h100, v); chk("R10 tx kept", v, 32'h01000000);
    ev_tx_all = 1; idle(1); ev_tx_all = 0;
    rd(12'h100, v); chk("R5 bit25", v, 32'h02000000);
    ev_link_chg = 1; rd(12'h120, v); ev_link_chg = 0;
    rd(12'h120, v); chk("R10 link kept", v, 32'h0000ffff);
    rd(12'h120, v); chk("R7 final", v, 0);

    // R11 unmapped offset
    rd(12'h000, v); chk("R11 unmapped", v, 0);
    idle(2);
    finish_run();
  end
endmodule